// File: doc/BRIEF.md
# Channel-Aware Interrupt Pending Controller

This block collects interrupt events for an audio engine with 64 voice channels and drives one active-low interrupt line. Global sources arrive as single-cycle pulses on a 32-bit event vector: interval timer, MIDI buffer status, half-full and full flags of three capture buffers, volume and mute buttons, bus error and a few others. Each pulse latches a bit in a global pending word. Per-channel loop events arrive on a 64-bit pulse vector and latch into two 32-bit channel pending words, each with its own 32-bit enable word.

Software reaches six registers over a simple synchronous write bus with a combinational read port. The global pending word also carries a summary of the channel state. Bit 6 shows that an enabled channel is pending, and bits 5:0 give the highest such channel. A write to the global word with bit 6 set retires exactly one channel, the one named in the written bits 5:0. An interrupt service routine can therefore drain the channels one at a time while touching only one register.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register reads 0 and `irq_n_o` is 1.
- R2: A pulse on `glb_evt_i[b]` for b in 7..24 sets global pending bit b at the next clock, and the bit stays set until it is cleared. Event bits 0..6 and 25..31 have no effect on any register.
- R3: Writing the global pending register (address 0) clears each bit 7..24 that is written as 1. Bits written as 0 keep their value.
- R4: If an event pulse and a write-1 clear hit the same pending bit in the same cycle, the bit is left set. This holds for global bits and for channel bits.
- R5: Global pending bit 6 reads 1 exactly when some channel c has both its pending bit and its enable bit set.
- R6: Global pending bits 5:0 read the highest channel number c that has both its pending and its enable bit set. They read 0 when there is no such channel.
- R7: A write to address 0 with bit 6 set clears the channel pending bit selected by written bits 5:0, and no other channel bit.
- R8: Channel pending bits for channels 0..31 sit at address 2 and bits for channels 32..63 at address 3, with channel c at bit c mod 32. These words are write-1-to-clear, and a pulse on `chan_evt_i[c]` sets bit c.
- R9: `irq_n_o` goes low one clock after the cycle in which any enabled source is pending. It goes high one clock after none is. Global pending bit p is gated by global enable bit e as follows: 7→0, 8→1, 9→2, 10→3, 11→4, 12 and 13→5, 14 and 15→6, 16 and 17→7, 18→8, 19→9, 20→10, 21→11, 22→14, 23→12, 24→13. Channels are gated by their channel enable bits.
- R10: While global enable bit 20 is set, `irq_n_o` is low from the next clock on, whatever is pending.
- R11: The global enable word (address 1) and the channel enable words (address 4 for channels 0..31, address 5 for 32..63) are plain 32-bit read/write storage. Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_evt_i | input | 32 | Global event pulses, one bit per pending bit |
| chan_evt_i | input | 64 | Per-channel loop event pulses |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_n_o | output | 1 | Registered active-low interrupt |

## Verification
The channel summary is exercised with the same set of pending channels under several enable patterns: none enabled, all enabled, and only the low word enabled. This separates a summary that ignores the enables from one that honours them, and a highest-channel search from a lowest-channel one. Clear-by-number is tried on the highest channel and checked to leave its neighbours set. A walk over every global source enables only its mapped enable bit, which exposes any mis-wired gating. Coincident event-and-clear cycles, addresses outside the map and the force bit each get a dedicated pattern. A behavioural model is compared with the read port and the interrupt line on every cycle.

// File: rtl/ipc_pkg.sv
// Package: shared constants and the global enable mapping for the
// interrupt pending controller. Assumes a 32-bit register word.
package ipc_pkg;
    localparam int DW        = 32;
    localparam int GLB_LO    = 7;
    localparam int GLB_HI    = 24;
    localparam int SUM_BIT   = 6;
    localparam int FORCE_BIT = 20;

    // Mask of the global bits that hold latched events.
    function automatic logic [DW-1:0] glb_mask();
        logic [DW-1:0] m;
        m = '0;
        for (int b = GLB_LO; b <= GLB_HI; b++) m[b] = 1'b1;
        return m;
    endfunction

    // Enable bit that gates a global pending bit; -1 when the bit has none.
    function automatic int glb_en_idx(input int p);
        case (p)
            7:       return 0;
            8:       return 1;
            9:       return 2;
            10:      return 3;
            11:      return 4;
            12, 13:  return 5;
            14, 15:  return 6;
            16, 17:  return 7;
            18:      return 8;
            19:      return 9;
            20:      return 10;
            21:      return 11;
            22:      return 14;
            23:      return 12;
            24:      return 13;
            default: return -1;
        endcase
    endfunction
endpackage

// File: rtl/ipc_pend_word.sv
// Module: one pending word. A set pulse latches a bit. A clear bit
// drops it unless a set arrives in the same cycle. Bits outside
// VALID_MASK stay zero. Assumes synchronous active-low reset.
module ipc_pend_word #(
    parameter int           W          = 32,
    parameter logic [W-1:0] VALID_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Latch events; a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr_i) | set_i) & VALID_MASK;
    end

    assign q_o = q;
endmodule

// File: rtl/ipc_high_find.sv
// Module: finds the highest set bit of a vector. idx_o is 0 when
// nothing is set. Purely combinational. Assumes N is a power of two.
module ipc_high_find #(
    parameter int N     = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan upward so that the last set bit, the highest, wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
// Module: interrupt pending controller with a per-channel summary.
// Address map: 0 global pending (W1C, bit 6 + bits 5:0 = channel
// summary), 1 global enable, 2.. channel pending words (W1C), then
// channel enable words. Assumes NUM_CH is a multiple of 32 and that
// the map fits in ADDR_W bits. Synchronous active-low reset.
module irq_pend_ctrl #(
    parameter int NUM_CH = 64,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         glb_evt_i,
    input  logic [NUM_CH-1:0]   chan_evt_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic                irq_n_o
);
    import ipc_pkg::*;

    localparam int CH_WORDS = NUM_CH / DW;
    localparam int CH_IDX_W = $clog2(NUM_CH);
    localparam int A_GPEND  = 0;
    localparam int A_GEN    = 1;
    localparam int A_CPEND  = 2;
    localparam int A_CEN    = A_CPEND + CH_WORDS;
    localparam logic [DW-1:0] GLB_MASK = glb_mask();

    logic              wr_gpend;
    logic [DW-1:0]     gclr;
    logic [DW-1:0]     gpend_q;
    logic [DW-1:0]     gen_q;
    logic [DW-1:0]     gact;
    logic [NUM_CH-1:0] chclr;
    logic [NUM_CH-1:0] cp_q;
    logic [NUM_CH-1:0] ce_q;
    logic              ch_any;
    logic [CH_IDX_W-1:0] ch_idx;
    logic              any_act;
    logic              irq_n_q;

    assign wr_gpend = bus_wr_i && (bus_addr_i == ADDR_W'(A_GPEND));
    assign gclr     = wr_gpend ? bus_wdata_i : '0;

    // Global pending word: event set, write-1 clear.
    ipc_pend_word #(.W(DW), .VALID_MASK(GLB_MASK)) u_gpend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (glb_evt_i),
        .clr_i (gclr),
        .q_o   (gpend_q)
    );

    // Global enable word: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       gen_q <= '0;
        else if (bus_wr_i && bus_addr_i == ADDR_W'(A_GEN)) gen_q <= bus_wdata_i;
    end

    // Channel clear: one channel by number, plus direct W1C per word.
    always_comb begin
        chclr = '0;
        if (wr_gpend && bus_wdata_i[SUM_BIT])
            chclr[bus_wdata_i[CH_IDX_W-1:0]] = 1'b1;
        for (int w = 0; w < CH_WORDS; w++) begin
            if (bus_wr_i && bus_addr_i == ADDR_W'(A_CPEND + w))
                chclr[w*DW +: DW] = chclr[w*DW +: DW] | bus_wdata_i;
        end
    end

    // Per-word channel pending and enable storage.
    for (genvar w = 0; w < CH_WORDS; w++) begin : g_chword
        ipc_pend_word #(.W(DW), .VALID_MASK('1)) u_cpend (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (chan_evt_i[w*DW +: DW]),
            .clr_i (chclr[w*DW +: DW]),
            .q_o   (cp_q[w*DW +: DW])
        );

        // Channel enable word w: plain storage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ce_q[w*DW +: DW] <= '0;
            else if (bus_wr_i && bus_addr_i == ADDR_W'(A_CEN + w))
                ce_q[w*DW +: DW] <= bus_wdata_i;
        end
    end

    // Highest enabled pending channel.
    ipc_high_find #(.N(NUM_CH)) u_find (
        .vec_i (cp_q & ce_q),
        .any_o (ch_any),
        .idx_o (ch_idx)
    );

    // Gate each global pending bit by its mapped enable bit.
    for (genvar b = 0; b < DW; b++) begin : g_gact
        localparam int EI = glb_en_idx(b);
        if (EI >= 0) begin : g_on
            assign gact[b] = gpend_q[b] & gen_q[EI];
        end else begin : g_off
            assign gact[b] = 1'b0;
        end
    end

    assign any_act = (|gact) | ch_any;

    // Registered interrupt line, forced low by the force enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~(any_act | gen_q[FORCE_BIT]);
    end

    assign irq_n_o = irq_n_q;

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(A_GPEND))
            bus_rdata_o = {gpend_q[DW-1:SUM_BIT+1], ch_any, ch_idx};
        else if (bus_addr_i == ADDR_W'(A_GEN))
            bus_rdata_o = gen_q;
        for (int w = 0; w < CH_WORDS; w++) begin
            if (bus_addr_i == ADDR_W'(A_CPEND + w)) bus_rdata_o = cp_q[w*DW +: DW];
            if (bus_addr_i == ADDR_W'(A_CEN + w))   bus_rdata_o = ce_q[w*DW +: DW];
        end
    end
endmodule

// File: rtl/ipc_checker.sv
// Module: property checker for irq_pend_ctrl, attached by bind.
// Assumes the default channel count width used by the summary field.
module ipc_checker #(
    parameter int NUM_CH = 64,
    parameter int ADDR_W = 3,
    localparam int CH_IDX_W = $clog2(NUM_CH)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [31:0]         glb_evt_i,
    input logic [NUM_CH-1:0]   chan_evt_i,
    input logic                bus_wr_i,
    input logic [ADDR_W-1:0]   bus_addr_i,
    input logic [31:0]         bus_wdata_i,
    input logic [31:0]         gpend_q,
    input logic [31:0]         gen_q,
    input logic [NUM_CH-1:0]   cp_q,
    input logic [NUM_CH-1:0]   ce_q,
    input logic                ch_any,
    input logic [CH_IDX_W-1:0] ch_idx,
    input logic                any_act,
    input logic                irq_n_o
);
    import ipc_pkg::*;
    localparam logic [31:0] GM = glb_mask();

    p_event_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(glb_evt_i & GM)) |=> ((gpend_q & $past(glb_evt_i & GM)) == $past(glb_evt_i & GM)));

    p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_any |-> ((cp_q & ce_q) == '0));

    p_chan_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_any |-> (cp_q[ch_idx] && ce_q[ch_idx]));

    p_chan_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == '0 && bus_wdata_i[SUM_BIT]
         && !chan_evt_i[bus_wdata_i[CH_IDX_W-1:0]])
        |=> !cp_q[$past(bus_wdata_i[CH_IDX_W-1:0])]);

    p_irq_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_act |=> !irq_n_o);

    p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_act && !gen_q[FORCE_BIT]) |=> irq_n_o);

    p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q[FORCE_BIT] |=> !irq_n_o);
endmodule

bind irq_pend_ctrl ipc_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ipc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_evt_i   (glb_evt_i),
    .chan_evt_i  (chan_evt_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .gpend_q     (gpend_q),
    .gen_q       (gen_q),
    .cp_q        (cp_q),
    .ce_q        (ce_q),
    .ch_any      (ch_any),
    .ch_idx      (ch_idx),
    .any_act     (any_act),
    .irq_n_o     (irq_n_o)
);

// File: tb/tb_irq_pend_ctrl.sv
module tb_irq_pend_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] glb_evt = '0;
    logic [63:0] chan_evt = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_ctrl dut (
        .clk(clk), .rst_n(rst_n), .glb_evt_i(glb_evt), .chan_evt_i(chan_evt),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_n_o(irq_n)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_gp, m_ge;
    logic [63:0] m_cp, m_ce;
    logic        m_irq;

    function automatic int ref_en(input int p);
        case (p)
            7: return 0;   8: return 1;   9: return 2;   10: return 3;
            11: return 4;  12: return 5;  13: return 5;  14: return 6;
            15: return 6;  16: return 7;  17: return 7;  18: return 8;
            19: return 9;  20: return 10; 21: return 11; 22: return 14;
            23: return 12; 24: return 13;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        logic [63:0] act;
        int hi;
        act = m_cp & m_ce;
        hi = -1;
        for (int c = 63; c >= 0; c--) if (act[c] && hi < 0) hi = c;
        case (a)
            3'd0: return {m_gp[31:7], (hi >= 0), (hi >= 0) ? 6'(hi) : 6'd0};
            3'd1: return m_ge;
            3'd2: return m_cp[31:0];
            3'd3: return m_cp[63:32];
            3'd4: return m_ce[31:0];
            3'd5: return m_ce[63:32];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gp = '0; m_ge = '0; m_cp = '0; m_ce = '0; m_irq = 1'b1;
        end else begin
            logic any;
            any = |(m_cp & m_ce) | m_ge[20];
            for (int p = 7; p <= 24; p++) if (m_gp[p] && m_ge[ref_en(p)]) any = 1'b1;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin
                        for (int p = 7; p <= 24; p++) if (bus_wdata[p]) m_gp[p] = 1'b0;
                        if (bus_wdata[6]) m_cp[bus_wdata[5:0]] = 1'b0;
                    end
                    3'd1: m_ge = bus_wdata;
                    3'd2: m_cp[31:0]  = m_cp[31:0]  & ~bus_wdata;
                    3'd3: m_cp[63:32] = m_cp[63:32] & ~bus_wdata;
                    3'd4: m_ce[31:0]  = bus_wdata;
                    3'd5: m_ce[63:32] = bus_wdata;
                    default: ;
                endcase
            end
            for (int p = 7; p <= 24; p++) if (glb_evt[p]) m_gp[p] = 1'b1;
            m_cp = m_cp | chan_evt;
            m_irq = ~any;
        end
    end

    // Compare read port and interrupt against the model every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] exp_d;
            exp_d = m_read(bus_addr);
            n_tests += 2;
            if (bus_rdata !== exp_d) begin
                n_fail++;
                $display("FAIL %s model compare addr=%0d actual=%h expected=%h",
                         (bus_addr == 0) ? "R3" : (bus_addr == 2 || bus_addr == 3) ? "R8" : "R11",
                         bus_addr, bus_rdata, exp_d);
            end
            if (irq_n !== m_irq) begin
                n_fail++;
                $display("FAIL R9 model compare irq_n actual=%b expected=%b", irq_n, m_irq);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d,
                       input logic [31:0] g, input logic [63:0] c);
        @(negedge clk); #1;
        bus_wr = wr; bus_addr = a; bus_wdata = d; glb_evt = g; chan_evt = c;
        @(negedge clk); #1;
        bus_wr = 1'b0; glb_evt = '0; chan_evt = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, '0, '0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin rd(3'(a), d); chk("R1 reset read", d, 32'h0); end
        chk("R1 reset irq_n", {31'b0, irq_n}, 32'h1);

        // R2: timer event latches, out-of-range events ignored
        cyc(1'b0, 0, 0, 32'h4000_0208, '0);
        idle(2);
        rd(0, d); chk("R2 event latch and ignore", d, 32'h0000_0200);
        chk("R9 no enable no irq", {31'b0, irq_n}, 32'h1);

        // R9: enable timer (enable bit 2)
        wr(1, 32'h4); idle(1);
        chk("R9 timer enabled irq", {31'b0, irq_n}, 32'h0);

        // R3: write 0 keeps, write 1 clears
        wr(0, 32'h0000_0100); rd(0, d); chk("R3 zero keeps", d, 32'h0000_0200);
        wr(0, 32'h0000_0200); rd(0, d); chk("R3 one clears", d, 32'h0);
        idle(1); chk("R9 irq released", {31'b0, irq_n}, 32'h1);

        // R4: event and clear together on the same bit
        cyc(1'b0, 0, 0, 32'h0000_8000, '0);
        cyc(1'b1, 0, 32'h0000_8000, 32'h0000_8000, '0);
        rd(0, d); chk("R4 event beats clear", d, 32'h0000_8000);
        wr(0, 32'hFFFF_FFFF);

        // R5/R6: channels 5, 33, 40 pending, none enabled
        cyc(1'b0, 0, 0, '0, (64'd1 << 5) | (64'd1 << 33) | (64'd1 << 40));
        rd(0, d); chk("R5 no enable no summary", d, 32'h0);
        rd(2, d); chk("R8 low word", d, 32'h20);
        rd(3, d); chk("R8 high word", d, 32'h0000_0102);
        wr(4, 32'hFFFF_FFFF);
        rd(0, d); chk("R6 low enabled only", d, 32'h45);
        wr(5, 32'hFFFF_FFFF);
        rd(0, d); chk("R6 highest channel", d, 32'h68);
        idle(1); chk("R9 channel irq", {31'b0, irq_n}, 32'h0);

        // R7: clear channel 40 by number
        wr(0, 32'h0000_0068);
        rd(0, d); chk("R7 next highest", d, 32'h61);
        rd(2, d); chk("R7 neighbour kept", d, 32'h20);
        // R4 on a channel: clear by number with same-cycle event
        cyc(1'b1, 0, 32'h0000_0061, '0, 64'd1 << 33);
        rd(3, d); chk("R4 channel event beats clear", d, 32'h2);

        // R8: direct W1C on the high word
        wr(3, 32'h2);
        rd(0, d); chk("R8 high word clear", d, 32'h45);
        wr(2, 32'h20);
        rd(0, d); chk("R5 summary drops", d, 32'h0);
        wr(4, 0); wr(5, 0);

        // R10: force bit
        wr(1, 32'h0010_0000); idle(1);
        chk("R10 force irq", {31'b0, irq_n}, 32'h0);
        wr(1, 32'h0); idle(1);
        chk("R10 force released", {31'b0, irq_n}, 32'h1);

        // R11: enable storage and unmapped addresses
        wr(1, 32'hA5A5_0000); rd(1, d); chk("R11 enable rw", d, 32'hA5A5_0000);
        wr(1, 32'h0);
        wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
        rd(6, d); chk("R11 addr6 zero", d, 32'h0);
        rd(7, d); chk("R11 addr7 zero", d, 32'h0);
        for (int a = 0; a < 6; a++) begin rd(3'(a), d); chk("R11 unmapped write no effect", d, 32'h0); end

        // R9: walk every global source through its mapped enable
        for (int p = 7; p <= 24; p++) begin
            cyc(1'b0, 0, 0, 32'h1 << p, '0);
            wr(1, ~(32'h1 << ref_en(p)) & ~32'h0010_0000); idle(1);
            chk($sformatf("R9 bit %0d wrong enable", p), {31'b0, irq_n}, 32'h1);
            wr(1, 32'h1 << ref_en(p)); idle(1);
            chk($sformatf("R9 bit %0d mapped enable", p), {31'b0, irq_n}, 32'h0);
            wr(1, 0); wr(0, 32'hFFFF_FF80); idle(1);
        end

        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule